// File: doc/BRIEF.md
# Floating-Point Control and Status Register Block

This block keeps the architectural control and status state for a scalar floating-point and SIMD execution unit. It holds a read-only identification word, two read-only feature words, a status/control word that user code can read and write, and an enable word that turns the whole unit on or off. The arithmetic datapath lives elsewhere. It sends compare results, per-operation exception pulses and saturation pulses to this block. It also asks whether each instruction it is about to issue must be rejected with an undefined-instruction trap.

System-register accesses carry a register select, a privilege level, a write flag and write data. Read data and the access-fault indication are registered and appear one cycle after the access. The rounding, flush-to-zero, default-NaN and alternative half-precision controls leave the block as separate outputs. The trap decision is combinational from the instruction-class query and the current register state.

Top module: `fp_ctrl_regs`

## Requirements
- R1: After reset the status word and the enable bit are 0, and `rd_data`, `access_fault` and `unit_en` are 0.
- R2: A compare result loads status bits [31:28] (N,Z,C,V). The `cmp_res` codes are 0 less-than, 1 equal, 2 greater-than and 3 unordered. They give the nibbles 4'b1000, 4'b0110, 4'b0010 and 4'b0011.
- R3: Status bit 27 is set by any `sat_pulse`. It stays set until a status write stores 0 there.
- R4: `exc_pulse` bits [5:0] set the sticky status bits 7, 4, 3, 2, 1 and 0 respectively (input denormal, inexact, underflow, overflow, divide-by-zero, invalid). Each stays set until a status write clears it.
- R5: `alt_half`, `default_nan` and `flush_zero` mirror status bits 26, 25 and 24. `round_mode` mirrors bits [23:22].
- R6: Status bits 19, 15:8 and 6:5 always read 0, and writes to them have no effect. The writable mask is 32'hFFF7_009F.
- R7: In the enable word (select 4), bit 30 is the unit enable driven on `unit_en`. All other bits read 0 and ignore writes.
- R8: Selects 0, 2, 3 and 4 need privilege 1 or higher. The selects are 0 identification, 1 status, 2 feature 0, 3 feature 1 and 4 enable. A lower-privilege access to them reads 0, changes nothing and raises `access_fault` for exactly one cycle. Status accesses are allowed at any privilege.
- R9: The identification and feature words read back their parameter values, and writes to them are ignored.
- R10: With the unit enabled, a data-processing query (`insn_class` 0) traps when status bits [18:16] or [21:20] are nonzero. Compare (1), convert (2) and SIMD (3) queries do not trap for this reason.
- R11: While `unit_en` is 0, every valid instruction query traps, whatever its class.
- R12: When a status write and a sticky-set pulse hit the same bit in one cycle, the written value is applied and the pulse is then ORed in.
- R13: When a status write and a compare result arrive in the same cycle, the compare result determines bits [31:28].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | System-register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 3 | Register select |
| acc_priv | input | 2 | Privilege level of the access |
| acc_wdata | input | 32 | Write data |
| cmp_valid | input | 1 | Compare result strobe |
| cmp_res | input | 2 | Compare outcome code |
| exc_pulse | input | 6 | Cumulative exception event pulses |
| sat_pulse | input | 1 | SIMD integer saturation pulse |
| insn_valid | input | 1 | Instruction trap query strobe |
| insn_class | input | 2 | Instruction class of the query |
| rd_data | output | 32 | Registered read data |
| round_mode | output | 2 | Rounding mode control |
| flush_zero | output | 1 | Flush-to-zero control |
| default_nan | output | 1 | Default-NaN control |
| alt_half | output | 1 | Alternative half-precision control |
| unit_en | output | 1 | Global unit enable |
| access_fault | output | 1 | One-cycle privilege fault indication |
| undef_trap | output | 1 | Undefined-instruction trap for the query |

## Verification
The bench targets same-cycle collisions. A write of zero that lands together with a saturation or exception pulse must keep the pulsed bit; a design that let the write win would lose an exception silently. A write together with a compare must leave the compare's flags; a design that gave the write priority would leave stale flags. Unprivileged accesses are checked both for the zero read and the one-cycle fault, and for leaving the enable bit untouched; a leaky gate would let user code switch the unit. The trap decode is probed per class, with only the length field set, with only the stride field set, and with the unit disabled. This catches a decode that exempts the wrong classes or tests only one of the two fields.

// File: rtl/fpcr_pkg.sv
package fpcr_pkg;
    localparam int XLEN = 32;
    localparam int NEXC = 6;

    typedef enum logic [2:0] {
        SEL_IDENT = 3'd0,
        SEL_STAT  = 3'd1,
        SEL_FEAT0 = 3'd2,
        SEL_FEAT1 = 3'd3,
        SEL_ENA   = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        CMP_LT = 2'd0,
        CMP_EQ = 2'd1,
        CMP_GT = 2'd2,
        CMP_UN = 2'd3
    } cmp_e;

    typedef enum logic [1:0] {
        IC_ARITH = 2'd0,
        IC_CMP   = 2'd1,
        IC_CVT   = 2'd2,
        IC_SIMD  = 2'd3
    } iclass_e;

    localparam logic [XLEN-1:0] STAT_WMASK = 32'hFFF7_009F;
    localparam int ENA_BIT  = 30;
    localparam int QC_BIT   = 27;
    localparam int IDC_BIT  = 7;

    typedef struct packed {
        logic [XLEN-1:0] stat;
    } stat_state_t;

    typedef struct packed {
        logic            en;
        logic            fault;
        logic [XLEN-1:0] rdata;
    } gate_state_t;

    function automatic logic [3:0] nzcv_of(input logic [1:0] res);
        logic [3:0] f;
        case (cmp_e'(res))
            CMP_LT:  f = 4'b1000;
            CMP_EQ:  f = 4'b0110;
            CMP_GT:  f = 4'b0010;
            default: f = 4'b0011;
        endcase
        return f;
    endfunction
endpackage

// File: rtl/fpcr_stat_reg.sv
module fpcr_stat_reg
    import fpcr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [XLEN-1:0]      wdata,
    input  logic                 cmp_valid,
    input  logic [1:0]           cmp_res,
    input  logic [NEXC-1:0]      exc_set,
    input  logic                 sat_set,
    output logic [XLEN-1:0]      stat_q
);
    stat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // software write first, masked to the implemented bits
        if (wr_en) begin
            st_d.stat = wdata & STAT_WMASK;
        end
        // compare flags override the write for the top nibble
        if (cmp_valid) begin
            st_d.stat[31:28] = nzcv_of(cmp_res);
        end
        // sticky sets are ORed on top of whatever was written
        st_d.stat[QC_BIT]  = st_d.stat[QC_BIT]  | sat_set;
        st_d.stat[IDC_BIT] = st_d.stat[IDC_BIT] | exc_set[NEXC-1];
        st_d.stat[NEXC-2:0] = st_d.stat[NEXC-2:0] | exc_set[NEXC-2:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_q = st_q.stat;
endmodule

// File: rtl/fpcr_access.sv
module fpcr_access
    import fpcr_pkg::*;
#(
    parameter logic [XLEN-1:0] ID_VALUE    = 32'h5A12_3401,
    parameter logic [XLEN-1:0] FEAT0_VALUE = 32'h1011_0222,
    parameter logic [XLEN-1:0] FEAT1_VALUE = 32'h1111_1111,
    parameter int              PRIV_W      = 2,
    parameter int              MIN_PRIV    = 1
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic [2:0]           acc_sel,
    input  logic [PRIV_W-1:0]    acc_priv,
    input  logic [XLEN-1:0]      acc_wdata,
    input  logic [XLEN-1:0]      stat_q,
    output logic                 stat_wr,
    output logic [XLEN-1:0]      rd_data,
    output logic                 fault,
    output logic                 unit_en
);
    gate_state_t g_d, g_q;
    logic        privileged;
    logic        allowed;
    reg_sel_e    sel;

    always_comb begin
        sel        = reg_sel_e'(acc_sel);
        privileged = (sel == SEL_IDENT) || (sel == SEL_FEAT0) ||
                     (sel == SEL_FEAT1) || (sel == SEL_ENA);
        allowed    = !privileged || (int'(acc_priv) >= MIN_PRIV);
        stat_wr    = acc_valid && acc_write && (sel == SEL_STAT);

        g_d        = g_q;
        g_d.fault  = acc_valid && privileged && !allowed;
        g_d.rdata  = '0;
        if (acc_valid && acc_write && allowed && (sel == SEL_ENA)) begin
            g_d.en = acc_wdata[ENA_BIT];
        end
        if (acc_valid && !acc_write && allowed) begin
            case (sel)
                SEL_IDENT: g_d.rdata = ID_VALUE;
                SEL_STAT:  g_d.rdata = stat_q;
                SEL_FEAT0: g_d.rdata = FEAT0_VALUE;
                SEL_FEAT1: g_d.rdata = FEAT1_VALUE;
                SEL_ENA:   g_d.rdata[ENA_BIT] = g_q.en;
                default:   g_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign rd_data = g_q.rdata;
    assign fault   = g_q.fault;
    assign unit_en = g_q.en;
endmodule

// File: rtl/fpcr_trap.sv
module fpcr_trap
    import fpcr_pkg::*;
(
    input  logic       insn_valid,
    input  logic [1:0] insn_class,
    input  logic       unit_en,
    input  logic [2:0] vec_len,
    input  logic [1:0] vec_stride,
    output logic       undef
);
    logic vec_set;
    logic is_arith;

    always_comb begin
        vec_set  = (vec_len != '0) || (vec_stride != '0);
        is_arith = (iclass_e'(insn_class) == IC_ARITH);
        undef    = insn_valid && (!unit_en || (is_arith && vec_set));
    end
endmodule

// File: rtl/fp_ctrl_regs.sv
module fp_ctrl_regs
    import fpcr_pkg::*;
#(
    parameter logic [31:0] ID_VALUE    = 32'h5A12_3401,
    parameter logic [31:0] FEAT0_VALUE = 32'h1011_0222,
    parameter logic [31:0] FEAT1_VALUE = 32'h1111_1111,
    parameter int          MIN_PRIV    = 1
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [2:0]  acc_sel,
    input  logic [1:0]  acc_priv,
    input  logic [31:0] acc_wdata,
    input  logic        cmp_valid,
    input  logic [1:0]  cmp_res,
    input  logic [5:0]  exc_pulse,
    input  logic        sat_pulse,
    input  logic        insn_valid,
    input  logic [1:0]  insn_class,
    output logic [31:0] rd_data,
    output logic [1:0]  round_mode,
    output logic        flush_zero,
    output logic        default_nan,
    output logic        alt_half,
    output logic        unit_en,
    output logic        access_fault,
    output logic        undef_trap
);
    logic [XLEN-1:0] stat_q;
    logic            stat_wr;

    fpcr_stat_reg u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (stat_wr),
        .wdata     (acc_wdata),
        .cmp_valid (cmp_valid),
        .cmp_res   (cmp_res),
        .exc_set   (exc_pulse),
        .sat_set   (sat_pulse),
        .stat_q    (stat_q)
    );

    fpcr_access #(
        .ID_VALUE    (ID_VALUE),
        .FEAT0_VALUE (FEAT0_VALUE),
        .FEAT1_VALUE (FEAT1_VALUE),
        .PRIV_W      (2),
        .MIN_PRIV    (MIN_PRIV)
    ) u_access (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_sel   (acc_sel),
        .acc_priv  (acc_priv),
        .acc_wdata (acc_wdata),
        .stat_q    (stat_q),
        .stat_wr   (stat_wr),
        .rd_data   (rd_data),
        .fault     (access_fault),
        .unit_en   (unit_en)
    );

    fpcr_trap u_trap (
        .insn_valid (insn_valid),
        .insn_class (insn_class),
        .unit_en    (unit_en),
        .vec_len    (stat_q[18:16]),
        .vec_stride (stat_q[21:20]),
        .undef      (undef_trap)
    );

    assign alt_half    = stat_q[26];
    assign default_nan = stat_q[25];
    assign flush_zero  = stat_q[24];
    assign round_mode  = stat_q[23:22];
endmodule

// File: rtl/fp_ctrl_regs_chk.sv
module fp_ctrl_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [2:0]  acc_sel,
    input logic [1:0]  acc_priv,
    input logic [5:0]  exc_pulse,
    input logic        sat_pulse,
    input logic        insn_valid,
    input logic [31:0] rd_data,
    input logic        unit_en,
    input logic        access_fault,
    input logic        undef_trap,
    input logic [31:0] stat_q
);
    // R3
    qc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sat_pulse |=> stat_q[27]);

    // R4
    ioc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pulse[0] |=> stat_q[0]);

    // R4
    idc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pulse[5] |=> stat_q[7]);

    // R6
    stat_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && acc_sel == 3'd1) |=> ((rd_data & ~32'hFFF7_009F) == 32'd0));

    // R7
    ena_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && acc_sel == 3'd4) |=> (!rd_data[31] && rd_data[29:0] == 30'd0));

    // R8
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        access_fault |-> ($past(acc_valid) && $past(acc_priv) == 2'd0 && $past(acc_sel) != 3'd1));

    // R8
    ena_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_sel == 3'd4 && acc_priv == 2'd0) |=> $stable(unit_en));

    // R11
    disabled_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && !unit_en) |-> undef_trap);
endmodule

bind fp_ctrl_regs fp_ctrl_regs_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_write    (acc_write),
    .acc_sel      (acc_sel),
    .acc_priv     (acc_priv),
    .exc_pulse    (exc_pulse),
    .sat_pulse    (sat_pulse),
    .insn_valid   (insn_valid),
    .rd_data      (rd_data),
    .unit_en      (unit_en),
    .access_fault (access_fault),
    .undef_trap   (undef_trap),
    .stat_q       (stat_q)
);

// File: tb/fp_ctrl_regs_tb_top.sv
module fp_ctrl_regs_tb_top;
    localparam logic [31:0] IDV = 32'hC3A5_7702;
    localparam logic [31:0] F0V = 32'h2221_0111;
    localparam logic [31:0] F1V = 32'h0111_1011;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [2:0]  acc_sel = '0;
    logic [1:0]  acc_priv = '0;
    logic [31:0] acc_wdata = '0;
    logic        cmp_valid = 1'b0;
    logic [1:0]  cmp_res = '0;
    logic [5:0]  exc_pulse = '0;
    logic        sat_pulse = 1'b0;
    logic        insn_valid = 1'b0;
    logic [1:0]  insn_class = '0;
    logic [31:0] rd_data;
    logic [1:0]  round_mode;
    logic        flush_zero, default_nan, alt_half, unit_en, access_fault, undef_trap;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    fp_ctrl_regs #(.ID_VALUE(IDV), .FEAT0_VALUE(F0V), .FEAT1_VALUE(F1V)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_sel(acc_sel), .acc_priv(acc_priv), .acc_wdata(acc_wdata),
        .cmp_valid(cmp_valid), .cmp_res(cmp_res), .exc_pulse(exc_pulse),
        .sat_pulse(sat_pulse), .insn_valid(insn_valid), .insn_class(insn_class),
        .rd_data(rd_data), .round_mode(round_mode), .flush_zero(flush_zero),
        .default_nan(default_nan), .alt_half(alt_half), .unit_en(unit_en),
        .access_fault(access_fault), .undef_trap(undef_trap)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock of stimulus driven from a falling edge; outputs sampled at the next falling edge
    task automatic step(input logic v, input logic w, input logic [2:0] s, input logic [1:0] p,
                        input logic [31:0] d, input logic cv, input logic [1:0] cr,
                        input logic [5:0] ex, input logic sat);
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_sel = s; acc_priv = p; acc_wdata = d;
        cmp_valid = cv; cmp_res = cr; exc_pulse = ex; sat_pulse = sat;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; cmp_valid = 1'b0; exc_pulse = '0; sat_pulse = 1'b0;
    endtask

    task automatic wr(input logic [2:0] s, input logic [1:0] p, input logic [31:0] d);
        step(1'b1, 1'b1, s, p, d, 1'b0, 2'd0, 6'd0, 1'b0);
    endtask

    task automatic rd(input logic [2:0] s, input logic [1:0] p);
        step(1'b1, 1'b0, s, p, 32'd0, 1'b0, 2'd0, 6'd0, 1'b0);
    endtask

    task automatic query(input logic [1:0] cls, output logic trap);
        insn_valid = 1'b1; insn_class = cls;
        #1 trap = undef_trap;
        insn_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 rd_data", rd_data, 32'd0);
        check("R1 fault", {31'd0, access_fault}, 32'd0);
        check("R1 unit_en", {31'd0, unit_en}, 32'd0);
        rd(3'd1, 2'd0);
        check("R1 status", rd_data, 32'd0);
    endtask

    task automatic t_enable();
        wr(3'd4, 2'd1, 32'hFFFF_FFFF);
        check("R7 unit_en", {31'd0, unit_en}, 32'd1);
        rd(3'd4, 2'd1);
        check("R7 enable read", rd_data, 32'h4000_0000);
    endtask

    task automatic t_priv();
        rd(3'd0, 2'd0);
        check("R8 ident read low priv", rd_data, 32'd0);
        check("R8 fault raised", {31'd0, access_fault}, 32'd1);
        @(negedge clk);
        check("R8 fault one cycle", {31'd0, access_fault}, 32'd0);
        wr(3'd4, 2'd0, 32'd0);
        check("R8 fault on write", {31'd0, access_fault}, 32'd1);
        check("R8 enable kept", {31'd0, unit_en}, 32'd1);
        rd(3'd1, 2'd0);
        check("R8 status no fault", {31'd0, access_fault}, 32'd0);
    endtask

    task automatic t_ident();
        rd(3'd0, 2'd1); check("R9 ident", rd_data, IDV);
        rd(3'd2, 2'd1); check("R9 feat0", rd_data, F0V);
        rd(3'd3, 2'd3); check("R9 feat1", rd_data, F1V);
        wr(3'd0, 2'd1, 32'h0);
        rd(3'd0, 2'd1); check("R9 ident after write", rd_data, IDV);
    endtask

    task automatic t_fields();
        wr(3'd1, 2'd0, 32'hFFFF_FFFF);
        rd(3'd1, 2'd0);
        check("R6 reserved masked", rd_data, 32'hFFF7_009F);
        check("R5 ctl all set", {26'd0, alt_half, default_nan, flush_zero, round_mode, 1'b0}, 32'h3E);
        wr(3'd1, 2'd0, 32'h0280_0000);
        check("R5 dn only rm2", {26'd0, alt_half, default_nan, flush_zero, round_mode, 1'b0}, 32'h14);
    endtask

    task automatic t_compare();
        logic [3:0] exp [4] = '{4'h8, 4'h6, 4'h2, 4'h3};
        wr(3'd1, 2'd0, 32'd0);
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b0, 3'd0, 2'd0, 32'd0, 1'b1, 2'(i), 6'd0, 1'b0);
            rd(3'd1, 2'd0);
            check("R2 nzcv", {28'd0, rd_data[31:28]}, {28'd0, exp[i]});
        end
    endtask

    task automatic t_sticky();
        wr(3'd1, 2'd0, 32'd0);
        step(1'b0, 1'b0, 3'd0, 2'd0, 32'd0, 1'b0, 2'd0, 6'd0, 1'b1);
        @(negedge clk);
        rd(3'd1, 2'd0); check("R3 qc held", rd_data, 32'h0800_0000);
        wr(3'd1, 2'd0, 32'd0);
        rd(3'd1, 2'd0); check("R3 qc cleared", rd_data, 32'd0);
        step(1'b0, 1'b0, 3'd0, 2'd0, 32'd0, 1'b0, 2'd0, 6'b000001, 1'b0);
        rd(3'd1, 2'd0); check("R4 invalid bit0", rd_data, 32'h0000_0001);
        step(1'b0, 1'b0, 3'd0, 2'd0, 32'd0, 1'b0, 2'd0, 6'b100000, 1'b0);
        rd(3'd1, 2'd0); check("R4 denormal bit7", rd_data, 32'h0000_0081);
        step(1'b0, 1'b0, 3'd0, 2'd0, 32'd0, 1'b0, 2'd0, 6'b011110, 1'b0);
        rd(3'd1, 2'd0); check("R4 all sticky", rd_data, 32'h0000_009F);
        wr(3'd1, 2'd0, 32'd0);
        rd(3'd1, 2'd0); check("R4 cleared by write", rd_data, 32'd0);
    endtask

    task automatic t_collide();
        wr(3'd1, 2'd0, 32'h0800_0000);
        step(1'b1, 1'b1, 3'd1, 2'd0, 32'd0, 1'b0, 2'd0, 6'd0, 1'b1);
        rd(3'd1, 2'd0); check("R12 qc write0 plus set", rd_data, 32'h0800_0000);
        step(1'b1, 1'b1, 3'd1, 2'd0, 32'h0000_0001, 1'b0, 2'd0, 6'b000010, 1'b0);
        rd(3'd1, 2'd0); check("R12 write plus dz", rd_data, 32'h0000_0003);
        step(1'b1, 1'b1, 3'd1, 2'd0, 32'hF000_0000, 1'b1, 2'd2, 6'd0, 1'b0);
        rd(3'd1, 2'd0); check("R13 compare beats write", rd_data, 32'h2000_0000);
    endtask

    task automatic t_trap();
        logic t;
        wr(3'd1, 2'd0, 32'd0);
        query(2'd0, t); check("R10 arith no vec", {31'd0, t}, 32'd0);
        wr(3'd1, 2'd0, 32'h0001_0000);
        query(2'd0, t); check("R10 arith len", {31'd0, t}, 32'd1);
        query(2'd1, t); check("R10 cmp exempt", {31'd0, t}, 32'd0);
        query(2'd2, t); check("R10 cvt exempt", {31'd0, t}, 32'd0);
        query(2'd3, t); check("R10 simd exempt", {31'd0, t}, 32'd0);
        wr(3'd1, 2'd0, 32'h0010_0000);
        query(2'd0, t); check("R10 arith stride", {31'd0, t}, 32'd1);
        wr(3'd1, 2'd0, 32'd0);
        wr(3'd4, 2'd1, 32'd0);
        check("R11 disabled", {31'd0, unit_en}, 32'd0);
        query(2'd1, t); check("R11 cmp trap disabled", {31'd0, t}, 32'd1);
        query(2'd3, t); check("R11 simd trap disabled", {31'd0, t}, 32'd1);
        query(2'd0, t); check("R11 arith trap disabled", {31'd0, t}, 32'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_priv();
        t_ident();
        t_fields();
        t_compare();
        t_sticky();
        t_collide();
        t_trap();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule